// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Inserter

This block sits in an E1 transmit path after basic frame generation. It receives a framed serial stream one bit per strobe. With each bit come the frame number inside a 16-frame multiframe, the timeslot number and the bit number inside the timeslot. The only bits it rewrites are bit 1 of timeslot 0 (slot 0, bit index 0) in each frame. All other bits are forwarded one clock later without change.

The multiframe has two halves of eight frames, called sub-multiframe I (frames 0-7) and sub-multiframe II (frames 8-15). The odd frames 1 to 11 carry a six-bit alignment word. The even frames carry four check bits, and each set of check bits is computed over the half that was sent before. Frames 13 and 15 carry the two error-report bits. A report bit comes from one of three sources: receive CRC error events that have been latched, two bits held in configuration, or the incoming stream itself. A relaxed mode rewrites only the check bits and forwards everything else unchanged.

Top module: `e1c4_mf_insert`

## Requirements
- R1: Every strobed bit appears on `dout` on the clock after its strobe, and `dout_vld` is high for exactly that one clock. With `crc_en` low, every bit is forwarded unchanged. After reset, `dout` and `dout_vld` are 0.
- R2: With `crc_en` high and `keep_align` low, bit 1 of TS0 in frames 1, 3, 5, 7, 9 and 11 carries 0, 0, 1, 0, 1, 1 in that order.
- R3: With `pat_inv` high, each of those six alignment bits is sent inverted.
- R4: With `crc_en` high, bit 1 of TS0 in the even frames carries check bits C1 to C4. Frames 0, 2, 4 and 6 carry the check value of the previous sub-multiframe II. Frames 8, 10, 12 and 14 carry the check value of the sub-multiframe I just sent. C1 is the most significant bit of the value.
- R5: The check value is the remainder modulo x^4+x+1 of the bits of one half as they leave on `dout`, taken in order, with the four check-bit positions counted as 0. The remainder register is cleared at the start of each half. Before the first complete half after reset, the inserted value is 0000.
- R6: With `crc_inv` high, the four inserted check bits are sent inverted.
- R7: In automatic report mode (`e_auto_dis` and `rx_mf_lost` both low), frame 13 reports sub-multiframe I and frame 15 reports sub-multiframe II. Each sends 0 if an error event for its half is pending, and 1 otherwise. This applies with `crc_en` high and `keep_align` low.
- R8: A pulse on `rx_err_i` or `rx_err_ii` sets the pending flag for its half. This happens with or without a strobe. A strobe on that half's report slot clears the flag in any mode. An event in the same clock as that slot is not used in the current slot; it stays pending for the next one.
- R9: Outside automatic mode, `si_dis` low puts `si_bits[1]` in frame 13 and `si_bits[0]` in frame 15. With `si_dis` high, both report positions are forwarded unchanged.
- R10: With `crc_en` and `keep_align` both high, only the check bits are inserted. The alignment positions and the report positions are forwarded unchanged.
- R11: Every bit other than bit 1 of TS0 is forwarded unchanged, whatever the controls are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | Strobe: `din` and the position inputs are valid |
| din | input | 1 | Serial data bit from the basic framer |
| frame_idx | input | 4 | Frame number inside the multiframe, 0 to 15 |
| slot_idx | input | 5 | Timeslot number, 0 to 31 |
| bit_idx | input | 3 | Bit number inside the timeslot; 0 is bit 1 |
| crc_en | input | 1 | Enable multiframe insertion |
| keep_align | input | 1 | Relaxed mode: insert the check bits only |
| pat_inv | input | 1 | Invert the six alignment bits |
| crc_inv | input | 1 | Invert the four check bits |
| e_auto_dis | input | 1 | Turn off automatic error reports |
| rx_mf_lost | input | 1 | Receive multiframe lost; also turns off automatic reports |
| si_dis | input | 1 | Forward the report positions instead of `si_bits` |
| si_bits | input | 2 | Report values: bit 1 for frame 13, bit 0 for frame 15 |
| rx_err_i | input | 1 | Receive CRC error event for sub-multiframe I |
| rx_err_ii | input | 1 | Receive CRC error event for sub-multiframe II |
| dout | output | 1 | Modified serial bit |
| dout_vld | output | 1 | `dout` is valid |

## Verification
Two things can fall in the same clock: a receive error event for a half and the strobe of that half's own report slot. The design must send the flag value from before that clock and keep the new event pending for the next multiframe. Directed stimulus raises `rx_err_i` exactly on the frame 13 report strobe and `rx_err_ii` exactly on the frame 15 report strobe. In automatic mode the bench then expects a 1 in the current slot and a 0 in the same slot of the following multiframe. A second coincidence is the clock that starts a half. In that clock the finished remainder must be inserted as C1 while the register is cleared, and the expected value is computed by an independent remainder model driven by the bits the bench expects on `dout`. Later multiframes use random data, random idle gaps, random events and random controls.

// File: rtl/e1c4_pkg.sv
package e1c4_pkg;

   // Role of the current bit inside the multiframe.
   typedef enum logic [2:0] {
      POS_DATA = 3'd0,
      POS_MFA  = 3'd1,
      POS_CRC  = 3'd2,
      POS_E1   = 3'd3,
      POS_E2   = 3'd4
   } pos_kind_e;

   // Where the report bits are taken from.
   typedef enum logic [1:0] {
      ESRC_AUTO = 2'd0,
      ESRC_CFG  = 2'd1,
      ESRC_KEEP = 2'd2
   } esrc_e;

endpackage

// File: rtl/e1c4_locate.sv
module e1c4_locate
   import e1c4_pkg::*;
#(
   parameter int MF_FRAMES = 16,
   parameter int SLOTS     = 32,
   parameter int SLOT_BITS = 8,
   parameter int CRC_W     = 4,
   parameter int PAT_W     = 6,
   parameter logic [PAT_W-1:0] PAT = 6'b001011,
   localparam int FW  = $clog2(MF_FRAMES),
   localparam int SW  = $clog2(SLOTS),
   localparam int BW  = $clog2(SLOT_BITS),
   localparam int CIW = $clog2(CRC_W)
) (
   input  logic [FW-1:0] frame_idx,
   input  logic [SW-1:0] slot_idx,
   input  logic [BW-1:0] bit_idx,
   output pos_kind_e     kind,
   output logic          mfa_bit,
   output logic [CIW-1:0] crc_idx,
   output logic          half_start
);

   initial begin
      assert (MF_FRAMES == 4 * CRC_W)
         else $error("multiframe length must be four times the check width");
      assert (PAT_W + 2 == MF_FRAMES / 2)
         else $error("odd frames must hold the pattern plus two report bits");
      assert ((1 << CIW) == CRC_W)
         else $error("check width must be a power of two");
   end

   logic          is_b1;
   logic [FW-2:0] pair;
   int            pair_i;

   assign is_b1  = (slot_idx == '0) && (bit_idx == '0);
   assign pair   = frame_idx[FW-1:1];
   assign pair_i = int'(pair);

   always_comb begin
      kind    = POS_DATA;
      mfa_bit = 1'b0;
      if (is_b1) begin
         if (!frame_idx[0]) begin
            kind = POS_CRC;
         end else if (pair_i < PAT_W) begin
            kind    = POS_MFA;
            mfa_bit = PAT[PAT_W-1-pair_i];
         end else if (pair_i == PAT_W) begin
            kind = POS_E1;
         end else begin
            kind = POS_E2;
         end
      end
   end

   assign crc_idx    = pair[CIW-1:0];
   assign half_start = is_b1 && (frame_idx[FW-2:0] == '0);

endmodule

// File: rtl/e1c4_crc.sv
module e1c4_crc #(
   parameter int CRC_W = 4,
   parameter logic [CRC_W-1:0] POLY = 4'b0011,
   localparam int CIW = $clog2(CRC_W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           stb,
   input  logic           half_start,
   input  logic           feed_bit,
   input  logic [CIW-1:0] crc_idx,
   output logic           crc_bit
);

   initial begin
      assert (CRC_W >= 2) else $error("check width too small");
   end

   logic [CRC_W-1:0] acc_q;
   logic [CRC_W-1:0] hold_q;
   logic [CRC_W-1:0] cur;
   logic [CRC_W-1:0] nxt;
   logic             fb;

   // At the first bit of a half the finished remainder is still in acc_q.
   assign cur     = half_start ? acc_q : hold_q;
   assign crc_bit = cur[CRC_W-1-int'(crc_idx)];

   assign fb  = acc_q[CRC_W-1] ^ feed_bit;
   assign nxt = {acc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         hold_q <= '0;
      end else if (stb) begin
         if (half_start) begin
            hold_q <= acc_q;
            acc_q  <= '0;
         end else begin
            acc_q <= nxt;
         end
      end
   end

   // R4: the held value moves only at the first bit of a half
   p_hold_moves_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb && half_start) |=> $stable(hold_q));

   // R5: the remainder starts again from zero after a half begins
   p_acc_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && half_start) |=> (acc_q == '0));

endmodule

// File: rtl/e1c4_ebit.sv
module e1c4_ebit
   import e1c4_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stb,
   input  pos_kind_e kind,
   input  logic      ev_i,
   input  logic      ev_ii,
   input  esrc_e     src,
   input  logic [1:0] si_bits,
   input  logic      din,
   output logic      e_val
);

   logic pend_i_q, pend_ii_q;
   logic take_i, take_ii;

   assign take_i  = stb && (kind == POS_E1);
   assign take_ii = stb && (kind == POS_E2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_i_q  <= 1'b0;
         pend_ii_q <= 1'b0;
      end else begin
         if (take_i)      pend_i_q <= ev_i;
         else if (ev_i)   pend_i_q <= 1'b1;
         if (take_ii)     pend_ii_q <= ev_ii;
         else if (ev_ii)  pend_ii_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (src)
         ESRC_AUTO: e_val = (kind == POS_E1) ? ~pend_i_q : ~pend_ii_q;
         ESRC_CFG:  e_val = (kind == POS_E1) ? si_bits[1] : si_bits[0];
         default:   e_val = din;
      endcase
   end

   // R8: a slot with no new event leaves its flag clear
   p_pend_i_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !ev_i) |=> !pend_i_q);
   p_pend_ii_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_ii && !ev_ii) |=> !pend_ii_q);
   // R8: an event is always remembered, even on its own slot
   p_event_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i && ev_ii) |=> (pend_i_q && pend_ii_q));

endmodule

// File: rtl/e1c4_mf_insert.sv
module e1c4_mf_insert
   import e1c4_pkg::*;
#(
   parameter int MF_FRAMES = 16,
   parameter int SLOTS     = 32,
   parameter int SLOT_BITS = 8,
   parameter int CRC_W     = 4,
   parameter logic [CRC_W-1:0] CRC_POLY = 4'b0011,
   parameter int PAT_W     = 6,
   parameter logic [PAT_W-1:0] MFA_PAT = 6'b001011,
   parameter bit OUT_REG   = 1'b1,
   localparam int FW  = $clog2(MF_FRAMES),
   localparam int SW  = $clog2(SLOTS),
   localparam int BW  = $clog2(SLOT_BITS),
   localparam int CIW = $clog2(CRC_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_stb,
   input  logic          din,
   input  logic [FW-1:0] frame_idx,
   input  logic [SW-1:0] slot_idx,
   input  logic [BW-1:0] bit_idx,
   input  logic          crc_en,
   input  logic          keep_align,
   input  logic          pat_inv,
   input  logic          crc_inv,
   input  logic          e_auto_dis,
   input  logic          rx_mf_lost,
   input  logic          si_dis,
   input  logic [1:0]    si_bits,
   input  logic          rx_err_i,
   input  logic          rx_err_ii,
   output logic          dout,
   output logic          dout_vld
);

   pos_kind_e      kind;
   logic           mfa_bit;
   logic [CIW-1:0] crc_idx;
   logic           half_start;
   logic           crc_bit;
   logic           e_val;
   logic           full_ins;
   esrc_e          src;
   logic           obit;
   logic           feed;

   e1c4_locate #(
      .MF_FRAMES (MF_FRAMES), .SLOTS (SLOTS), .SLOT_BITS (SLOT_BITS),
      .CRC_W (CRC_W), .PAT_W (PAT_W), .PAT (MFA_PAT)
   ) u_loc (
      .frame_idx (frame_idx), .slot_idx (slot_idx), .bit_idx (bit_idx),
      .kind (kind), .mfa_bit (mfa_bit), .crc_idx (crc_idx),
      .half_start (half_start)
   );

   e1c4_crc #(.CRC_W (CRC_W), .POLY (CRC_POLY)) u_crc (
      .clk (clk), .rst_n (rst_n), .stb (bit_stb), .half_start (half_start),
      .feed_bit (feed), .crc_idx (crc_idx), .crc_bit (crc_bit)
   );

   always_comb begin
      if (!e_auto_dis && !rx_mf_lost) src = ESRC_AUTO;
      else if (!si_dis)               src = ESRC_CFG;
      else                            src = ESRC_KEEP;
   end

   e1c4_ebit u_ebit (
      .clk (clk), .rst_n (rst_n), .stb (bit_stb), .kind (kind),
      .ev_i (rx_err_i), .ev_ii (rx_err_ii), .src (src),
      .si_bits (si_bits), .din (din), .e_val (e_val)
   );

   assign full_ins = crc_en && !keep_align;

   always_comb begin
      obit = din;
      unique case (kind)
         POS_MFA: if (full_ins) obit = mfa_bit ^ pat_inv;
         POS_CRC: if (crc_en)   obit = crc_bit ^ crc_inv;
         POS_E1,
         POS_E2:  if (full_ins) obit = e_val;
         default: obit = din;
      endcase
   end

   // Check-bit positions count as zero in the remainder.
   assign feed = (kind == POS_CRC) ? 1'b0 : obit;

   generate
      if (OUT_REG) begin : g_reg
         logic is_b1;
         assign is_b1 = (kind != POS_DATA);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dout     <= 1'b0;
               dout_vld <= 1'b0;
            end else begin
               dout_vld <= bit_stb;
               if (bit_stb) dout <= obit;
            end
         end

         // R1: one valid clock per strobe, one clock later
         p_vld_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
            bit_stb |=> dout_vld);
         p_vld_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !bit_stb |=> !dout_vld);
         // R1: disabled insertion forwards the data
         p_pass_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_stb && !crc_en) |=> (dout == $past(din)));
         // R11: only bit 1 of TS0 may differ from the input
         p_payload_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_stb && !is_b1) |=> (dout == $past(din)));
         // R10: relaxed mode leaves the odd-frame positions alone
         p_relaxed_odd_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_stb && keep_align && is_b1 && frame_idx[0]) |=> (dout == $past(din)));
      end else begin : g_comb
         assign dout     = obit;
         assign dout_vld = bit_stb;
      end
   endgenerate

endmodule

// File: tb/tb_e1c4_mf_insert.sv
`timescale 1ns/1ps
module tb_e1c4_mf_insert;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0, din = 1'b0;
   logic [3:0] frame_idx = '0;
   logic [4:0] slot_idx = '0;
   logic [2:0] bit_idx = '0;
   logic       crc_en = 1'b0, keep_align = 1'b0, pat_inv = 1'b0, crc_inv = 1'b0;
   logic       e_auto_dis = 1'b0, rx_mf_lost = 1'b0, si_dis = 1'b0;
   logic [1:0] si_bits = '0;
   logic       rx_err_i = 1'b0, rx_err_ii = 1'b0;
   logic       dout, dout_vld;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   // model state
   logic [3:0] m_acc = '0, m_hold = '0;
   logic       m_p1 = 1'b0, m_p2 = 1'b0;
   localparam logic [5:0] ALIGN = 6'b001011;

   always #2.5 clk = ~clk;

   e1c4_mf_insert dut (
      .clk (clk), .rst_n (rst_n), .bit_stb (bit_stb), .din (din),
      .frame_idx (frame_idx), .slot_idx (slot_idx), .bit_idx (bit_idx),
      .crc_en (crc_en), .keep_align (keep_align), .pat_inv (pat_inv),
      .crc_inv (crc_inv), .e_auto_dis (e_auto_dis), .rx_mf_lost (rx_mf_lost),
      .si_dis (si_dis), .si_bits (si_bits), .rx_err_i (rx_err_i),
      .rx_err_ii (rx_err_ii), .dout (dout), .dout_vld (dout_vld)
   );

   task automatic check(input string req, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b (frame %0d slot %0d bit %0d)",
                  req, act, exp, frame_idx, slot_idx, bit_idx);
      end
   endtask

   function automatic logic [3:0] rem_step(input logic [3:0] r, input logic b);
      logic top;
      top = r[3] ^ b;
      rem_step = {r[2:0], 1'b0} ^ {2'b00, top, top};
   endfunction

   // Drive one strobed bit at a negedge, check it at the following negedge.
   task automatic send(input int f, input int s, input int b,
                       input logic d, input logic e1, input logic e2);
      logic exp;
      string tag;
      bit b1;
      int k;
      b1 = (s == 0) && (b == 0);
      k  = f / 2;
      exp = d;
      tag = "R11";
      bit_stb = 1'b1; din = d;
      frame_idx = 4'(f); slot_idx = 5'(s); bit_idx = 3'(b);
      rx_err_i = e1; rx_err_ii = e2;
      if (b1) begin
         if (f % 8 == 0) begin
            m_hold = m_acc;
            m_acc  = '0;
         end
         if (f % 2 == 0) begin
            tag = crc_inv ? "R4 R5 R6" : "R4 R5";
            if (!crc_en) tag = "R1";
            if (crc_en) exp = m_hold[3 - (k % 4)] ^ crc_inv;
         end else if (k < 6) begin
            tag = keep_align ? "R10" : (pat_inv ? "R3" : "R2");
            if (!crc_en) tag = "R1";
            if (crc_en && !keep_align) exp = ALIGN[5 - k] ^ pat_inv;
         end else begin
            logic pend, cfg;
            pend = (k == 6) ? m_p1 : m_p2;
            cfg  = (k == 6) ? si_bits[1] : si_bits[0];
            tag = keep_align ? "R10" : "R7 R8";
            if (!crc_en) tag = "R1";
            if (crc_en && !keep_align) begin
               if (!e_auto_dis && !rx_mf_lost) exp = ~pend;
               else begin
                  tag = "R9";
                  if (!si_dis) exp = cfg;
               end
            end
            if (k == 6) m_p1 = e1; else m_p2 = e2;
         end
      end else if (!crc_en) begin
         tag = "R1 R11";
      end
      if (!(b1 && k == 6 && f % 2 == 1)) m_p1 = m_p1 | e1;
      if (!(b1 && k == 7 && f % 2 == 1)) m_p2 = m_p2 | e2;
      m_acc = rem_step(m_acc, (b1 && f % 2 == 0) ? 1'b0 : exp);
      @(negedge clk);
      bit_stb = 1'b0; rx_err_i = 1'b0; rx_err_ii = 1'b0;
      check("R1 valid", dout_vld, 1'b1);
      check(tag, dout, exp);
   endtask

   task automatic idle(input logic e1, input logic e2);
      bit_stb = 1'b0; rx_err_i = e1; rx_err_ii = e2;
      m_p1 = m_p1 | e1;
      m_p2 = m_p2 | e2;
      @(negedge clk);
      rx_err_i = 1'b0; rx_err_ii = 1'b0;
      check("R1 idle", dout_vld, 1'b0);
   endtask

   task automatic set_mode(input int mf);
      crc_en = 1'b1; keep_align = 1'b0; pat_inv = 1'b0; crc_inv = 1'b0;
      e_auto_dis = 1'b0; rx_mf_lost = 1'b0; si_dis = 1'b0; si_bits = 2'b00;
      case (mf)
         4: begin pat_inv = 1'b1; crc_inv = 1'b1; e_auto_dis = 1'b1; si_bits = 2'b10; end
         5: begin keep_align = 1'b1; rx_mf_lost = 1'b1; si_dis = 1'b1; end
         6: crc_en = 1'b0;
         7: begin e_auto_dis = 1'b1; si_dis = 1'b1; end
         default: if (mf > 7) begin
            crc_en = ($urandom % 4) != 0;
            keep_align = ($urandom % 4) == 0;
            pat_inv = 1'($urandom);
            crc_inv = 1'($urandom);
            e_auto_dis = ($urandom % 3) == 0;
            rx_mf_lost = ($urandom % 4) == 0;
            si_dis = 1'($urandom);
            si_bits = 2'($urandom);
         end
      endcase
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         vectors++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5e1c));
      repeat (4) @(negedge clk);
      check("R1 reset dout", dout, 1'b0);
      check("R1 reset valid", dout_vld, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int mf = 0; mf < 11; mf++) begin
         set_mode(mf);
         for (int f = 0; f < 16; f++) begin
            for (int s = 0; s < 32; s++) begin
               for (int b = 0; b < 8; b++) begin
                  logic e1, e2, b1;
                  b1 = (s == 0) && (b == 0);
                  e1 = 1'b0; e2 = 1'b0;
                  if (mf >= 8) begin
                     e1 = ($urandom % 700) == 0;
                     e2 = ($urandom % 700) == 0;
                  end
                  // R8 directed: set before the slot, then on the slot itself
                  if (mf == 1 && b1 && f == 3)  e1 = 1'b1;
                  if (mf == 1 && b1 && f == 9)  e2 = 1'b1;
                  if (mf == 2 && b1 && f == 13) e1 = 1'b1;
                  if (mf == 2 && b1 && f == 15) e2 = 1'b1;
                  if (mf >= 7 && ($urandom % 5) == 0)
                     idle(($urandom % 300) == 0, ($urandom % 300) == 0);
                  send(f, s, b, 1'($urandom), e1, e2);
               end
            end
         end
      end
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule